// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers per-channel completion events from a bank of DMA channels and presents them to software as latched status bits, gated by per-event enable bits, and merged into a single interrupt request line. Every channel has three event kinds: half of the current transfer moved, one descriptor finished, and the whole descriptor chain finished. Each channel owns one 4-bit nibble in a 32-bit register, so eight channels share a register and the default sixteen channels spread across two enable registers and two status registers.

Software programs the enable registers and reads the status registers over a simple register port. It acknowledges events by writing ones to the status bits it has handled. A separate read-only word reports which channels are currently active. The read port is registered: data for a read request appears one clock later and holds until the next read.

Top module: `dmairq_aggr`

## Requirements
- R1: After reset, every enable bit and every status bit is zero and `irq` is low.
- R2: Enable register g sits at byte offset 0x00 + 4*g and status register g at 0x10 + 4*g. Channel n lives in register n/8, in bits [4*(n%8)+3 : 4*(n%8)]. A write to an enable register replaces its stored bits, and a read returns them on `rd_data` one cycle after `rd_en`.
- R3: Inside a channel nibble, bit 0 latches the half-transfer event, bit 1 latches the descriptor-done event and bit 2 latches the chain-done event. A pulse sets its status bit on the next clock edge whether or not that bit is enabled.
- R4: A write to a status register clears exactly the bits that are one in the written value and leaves all other status bits unchanged. Writing zero changes nothing.
- R5: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is high exactly while at least one status bit is set and its matching enable bit is set.
- R7: With both enable registers written to zero, `irq` stays low while the latched status bits remain readable.
- R8: Bit 3 of every nibble in the enable and status registers reads as zero, and writing a one to it has no effect.
- R9: Offset 0x30 returns the `ch_active` inputs in bits [15:0] with zeros above. Writes to it are ignored. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_half | input | NUM_CH | Half-transfer event pulse, one per channel |
| evt_pkg | input | NUM_CH | Descriptor-done event pulse, one per channel |
| evt_queue | input | NUM_CH | Chain-done event pulse, one per channel |
| ch_active | input | NUM_CH | Channel busy level, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | DATA_W | Register write value |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | DATA_W | Read value, valid the cycle after `rd_en` |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an event pulse landing in the very cycle that software clears the same status bit, since it needs the channel side and the register side aligned on one edge. The stimulus table carries the event pulses and the write in the same row, so both are driven for one shared clock cycle, and the following read shows whether the bit survived. The stimulus also masks all enables while status is still pending, which shows that the line drops and the status stays readable.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  // Nibble layout inside each register
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned EVT_N  = 3;
  localparam int unsigned BIT_HALF  = 0;
  localparam int unsigned BIT_PKG   = 1;
  localparam int unsigned BIT_QUEUE = 2;

  // Address map (byte offsets)
  localparam int unsigned EN_BASE    = 32'h00;
  localparam int unsigned ST_BASE    = 32'h10;
  localparam int unsigned GLB_OFF    = 32'h30;
  localparam int unsigned REG_STRIDE = 4;

  // Mask of the reserved top bit of every nibble in a word of the given width
  function automatic logic [63:0] rsv_mask(input int unsigned width);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = NIB_W - 1; i < width; i += NIB_W) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
  import dmairq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NGRP   = 2
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NGRP-1:0]   en_wsel,
  output logic [NGRP-1:0]   st_wsel,
  output logic [NGRP-1:0]   en_rsel,
  output logic [NGRP-1:0]   st_rsel,
  output logic              glb_rsel
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_BASE + REG_STRIDE * g);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(ST_BASE + REG_STRIDE * g);
    assign en_wsel[g] = wr_en && (wr_addr == EN_A);
    assign st_wsel[g] = wr_en && (wr_addr == ST_A);
    assign en_rsel[g] = (rd_addr == EN_A);
    assign st_rsel[g] = (rd_addr == ST_A);
  end

  assign glb_rsel = (rd_addr == ADDR_W'(GLB_OFF));
endmodule

// File: rtl/dmairq_slot.sv
module dmairq_slot
  import dmairq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt,
  input  logic             en_we,
  input  logic             st_we,
  input  logic [NIB_W-1:0] wr_nib,
  output logic [EVT_N-1:0] en_q,
  output logic [EVT_N-1:0] st_q,
  output logic             pend
);
  logic [EVT_N-1:0] clr;
  logic             nib_unused;

  // Top nibble bit is reserved and never stored
  assign nib_unused = wr_nib[NIB_W-1];
  assign clr = st_we ? wr_nib[EVT_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we) en_q <= wr_nib[EVT_N-1:0];
      // A fresh event overrides a same-cycle clear
      st_q <= (st_q & ~clr) | evt;
    end
  end

  assign pend = |(en_q & st_q);
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 16,
  parameter int unsigned CH_PER_REG = 8,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [NUM_CH/CH_PER_REG-1:0] en_rsel,
  input  logic [NUM_CH/CH_PER_REG-1:0] st_rsel,
  input  logic                         glb_rsel,
  input  logic [NUM_CH-1:0][EVT_N-1:0] en_q,
  input  logic [NUM_CH-1:0][EVT_N-1:0] st_q,
  input  logic [NUM_CH-1:0]            ch_active,
  output logic [DATA_W-1:0]            rd_data
);
  localparam int unsigned NGRP = NUM_CH / CH_PER_REG;

  logic [NGRP-1:0][DATA_W-1:0] en_word;
  logic [NGRP-1:0][DATA_W-1:0] st_word;
  logic [DATA_W-1:0]           rd_next;

  for (genvar g = 0; g < NGRP; g++) begin : g_word
    for (genvar c = 0; c < CH_PER_REG; c++) begin : g_nib
      assign en_word[g][NIB_W*c +: NIB_W] = {1'b0, en_q[g*CH_PER_REG+c]};
      assign st_word[g][NIB_W*c +: NIB_W] = {1'b0, st_q[g*CH_PER_REG+c]};
    end
    if (DATA_W > NIB_W * CH_PER_REG) begin : g_pad
      assign en_word[g][DATA_W-1:NIB_W*CH_PER_REG] = '0;
      assign st_word[g][DATA_W-1:NIB_W*CH_PER_REG] = '0;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (en_rsel[g]) rd_next = rd_next | en_word[g];
      if (st_rsel[g]) rd_next = rd_next | st_word[g];
    end
    if (glb_rsel) rd_next = rd_next | DATA_W'(ch_active);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/dmairq_aggr.sv
module dmairq_aggr
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 16,
  parameter int unsigned CH_PER_REG = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_pkg,
  input  logic [NUM_CH-1:0] evt_queue,
  input  logic [NUM_CH-1:0] ch_active,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int unsigned NGRP = NUM_CH / CH_PER_REG;

  logic [NGRP-1:0]              en_wsel, st_wsel, en_rsel, st_rsel;
  logic                         glb_rsel;
  logic [NUM_CH-1:0][EVT_N-1:0] evt_all;
  logic [NUM_CH-1:0][EVT_N-1:0] en_q;
  logic [NUM_CH-1:0][EVT_N-1:0] st_q;
  logic [NUM_CH-1:0]            pend;

  dmairq_decode #(.ADDR_W(ADDR_W), .NGRP(NGRP)) u_decode (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .en_wsel  (en_wsel),
    .st_wsel  (st_wsel),
    .en_rsel  (en_rsel),
    .st_rsel  (st_rsel),
    .glb_rsel (glb_rsel)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam int unsigned GRP = n / CH_PER_REG;
    localparam int unsigned POS = n % CH_PER_REG;
    always_comb begin
      evt_all[n]            = '0;
      evt_all[n][BIT_HALF]  = evt_half[n];
      evt_all[n][BIT_PKG]   = evt_pkg[n];
      evt_all[n][BIT_QUEUE] = evt_queue[n];
    end
    dmairq_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_all[n]),
      .en_we  (en_wsel[GRP]),
      .st_we  (st_wsel[GRP]),
      .wr_nib (wr_data[NIB_W*POS +: NIB_W]),
      .en_q   (en_q[n]),
      .st_q   (st_q[n]),
      .pend   (pend[n])
    );
  end

  if (DATA_W > NIB_W * CH_PER_REG) begin : g_wpad
    logic wpad_unused;
    assign wpad_unused = ^wr_data[DATA_W-1:NIB_W*CH_PER_REG];
  end

  dmairq_rdmux #(.NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .DATA_W(DATA_W)) u_rdmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .en_rsel   (en_rsel),
    .st_rsel   (st_rsel),
    .glb_rsel  (glb_rsel),
    .en_q      (en_q),
    .st_q      (st_q),
    .ch_active (ch_active),
    .rd_data   (rd_data)
  );

  assign irq = |pend;
endmodule

// File: rtl/dmairq_aggr_chk.sv
module dmairq_aggr_chk
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 16,
  parameter int unsigned CH_PER_REG = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0][EVT_N-1:0] evt_all,
  input logic [NUM_CH-1:0][EVT_N-1:0] en_q,
  input logic [NUM_CH-1:0][EVT_N-1:0] st_q,
  input logic [NUM_CH-1:0]            ch_active,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic                         rd_en,
  input logic [ADDR_W-1:0]            rd_addr,
  input logic [DATA_W-1:0]            rd_data,
  input logic                         irq
);
  localparam int unsigned NGRP = NUM_CH / CH_PER_REG;
  localparam logic [DATA_W-1:0] RSV = DATA_W'(rsv_mask(DATA_W));

  logic st_write;
  assign st_write = wr_en && (wr_addr >= ADDR_W'(ST_BASE))
                    && (wr_addr < ADDR_W'(ST_BASE + REG_STRIDE * NGRP))
                    && (wr_addr[1:0] == 2'b00);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (st_q == '0 && en_q == '0 && !irq)); // R1

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(evt_all)) == $past(evt_all))); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !st_write |=> ((st_q & $past(st_q)) == $past(st_q))); // R4

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_q != '0 && en_q != '0)); // R6

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R7

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(rd_addr) < ADDR_W'(GLB_OFF)) |-> ((rd_data & RSV) == '0)); // R8

  AST_GLB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(rd_addr) == ADDR_W'(GLB_OFF)) |-> (rd_data == DATA_W'($past(ch_active)))); // R9
endmodule

bind dmairq_aggr dmairq_aggr_chk #(
  .NUM_CH(NUM_CH), .CH_PER_REG(CH_PER_REG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_all   (evt_all),
  .en_q      (en_q),
  .st_q      (st_q),
  .ch_active (ch_active),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/dmairq_aggr_bench.sv
module dmairq_aggr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_half = '0, evt_pkg = '0, evt_queue = '0, ch_active = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmairq_aggr u_dmairq_aggr (
    .clk(clk), .rst_n(rst_n), .evt_half(evt_half), .evt_pkg(evt_pkg),
    .evt_queue(evt_queue), .ch_active(ch_active), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] h;
    logic [15:0] p;
    logic [15:0] q;
    logic        wr;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] rexp;
    logic        iexp;
    logic [3:0]  req;
  } row_t;

  localparam int NROW = 13;
  localparam row_t TBL [NROW] = '{
    '{16'h0, 16'h0, 16'h0, 1'b0, 8'h00, 32'h0,        8'h00, 32'h0,        1'b0, 4'd1}, // R1 idle
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h00, 32'hFFFFFFFF, 8'h00, 32'h77777777, 1'b0, 4'd2}, // R2 enable grp0
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h04, 32'h00000020, 8'h04, 32'h00000020, 1'b0, 4'd2}, // R2 ch9 pkg enable
    '{16'h0200, 16'h0, 16'h0, 1'b0, 8'h00, 32'h0,     8'h14, 32'h00000010, 1'b0, 4'd3}, // R3 ch9 half unenabled
    '{16'h0, 16'h0, 16'h0008, 1'b0, 8'h00, 32'h0,     8'h10, 32'h00004000, 1'b1, 4'd3}, // R3 ch3 queue
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h10, 32'h0,        8'h10, 32'h00004000, 1'b1, 4'd4}, // R4 zero write
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h10, 32'h00004000, 8'h10, 32'h0,        1'b0, 4'd4}, // R4 clear ch3
    '{16'h0, 16'h0200, 16'h0, 1'b1, 8'h14, 32'h00000020, 8'h14, 32'h00000030, 1'b1, 4'd5}, // R5 event vs clear
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h14, 32'h00000010, 8'h14, 32'h00000020, 1'b1, 4'd4}, // R4 selective clear
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h00, 32'h0,        8'h04, 32'h00000020, 1'b1, 4'd6}, // R6 still pending
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h04, 32'h0,        8'h14, 32'h00000020, 1'b0, 4'd7}, // R7 all masked
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h14, 32'h88888888, 8'h14, 32'h00000020, 1'b0, 4'd8}, // R8 reserved clear
    '{16'h0, 16'h0, 16'h0, 1'b1, 8'h04, 32'hFFFFFFFF, 8'h04, 32'h77777777, 1'b1, 4'd8}  // R8 reserved enable, R6
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] h, input logic [15:0] p, input logic [15:0] q,
                      input logic wr, input logic [7:0] wa, input logic [31:0] wd,
                      input logic [7:0] ra);
    @(negedge clk);
    evt_half = h; evt_pkg = p; evt_queue = q;
    wr_en = wr; wr_addr = wa; wr_data = wd;
    @(negedge clk);
    evt_half = '0; evt_pkg = '0; evt_queue = '0; wr_en = 1'b0;
    rd_en = 1'b1; rd_addr = ra;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check1("R1", irq, 1'b0);

    for (int i = 0; i < NROW; i++) begin
      step(TBL[i].h, TBL[i].p, TBL[i].q, TBL[i].wr, TBL[i].wa, TBL[i].wd, TBL[i].ra);
      check32($sformatf("R%0d row %0d", TBL[i].req, i), rd_data, TBL[i].rexp);
      check1($sformatf("R%0d row %0d", TBL[i].req, i), irq, TBL[i].iexp);
    end

    // R3: all three events of the last channel land in nibble 7 of status reg 1
    step(16'h8000, 16'h8000, 16'h8000, 1'b0, 8'h00, 32'h0, 8'h14);
    check32("R3 ch15 all kinds", rd_data, 32'h70000020);
    check1("R6 ch15 enabled", irq, 1'b1);

    // R9: busy word follows ch_active, ignores writes; unmapped reads zero
    ch_active = 16'hA5C3;
    step(16'h0, 16'h0, 16'h0, 1'b1, 8'h30, 32'hFFFFFFFF, 8'h30);
    check32("R9 busy word", rd_data, 32'h0000A5C3);
    step(16'h0, 16'h0, 16'h0, 1'b0, 8'h00, 32'h0, 8'h20);
    check32("R9 unmapped", rd_data, 32'h0);

    // R1: reset while status and enables are set
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check1("R1 after reset", irq, 1'b0);
    check32("R1 rd_data cleared", rd_data, 32'h0);
    step(16'h0, 16'h0, 16'h0, 1'b0, 8'h00, 32'h0, 8'h14);
    check32("R1 status cleared", rd_data, 32'h0);
    step(16'h0, 16'h0, 16'h0, 1'b0, 8'h00, 32'h0, 8'h04);
    check32("R1 enable cleared", rd_data, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule